// File: doc/BRIEF.md
# Precomputation-Gated Magnitude Comparator

This block registers two unsigned operands and reports whether the first is strictly greater than the second. It is built to keep switching activity low. The most significant bit of each operand goes into its own flop on every cycle. The remaining lower bits go into a separate register bank, and that bank loads only when the two incoming top bits match. When the top bits differ, the top bit alone settles the answer. The lower bank and its comparator then keep their old values for that cycle and do not toggle.

Gating of the lower bank is modelled as a synchronous load enable, with no latch-based clock cell. A registered flag shows each cycle in which the lower bank took new data. A free-running counter of those cycles lets a bench or monitor measure how often the wide slice was woken. With uniformly random operands, the lower bank stays idle in about half of all cycles.

Top module: `precomp_gt_cmp`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears all state. After it, `gt_o` is 0, `lo_load_o` is 0 and `load_cnt_o` is 0.
- R2: Operands presented before a rising edge produce their result in the cycle after that edge. In that cycle `gt_o` is 1 exactly when `a_i > b_i` as unsigned numbers.
- R3: When bit WIDTH-1 of the operands differs, `gt_o` follows bit WIDTH-1 of `a_i`. A=1 with B=0 gives 1, and A=0 with B=1 gives 0, whatever the lower bits hold.
- R4: `lo_load_o` is 1 in the cycle after an edge exactly when bit WIDTH-1 of `a_i` equalled bit WIDTH-1 of `b_i` at that edge. Otherwise it is 0, and the lower bank keeps its previous contents.
- R5: When the top bits are equal, the result comes from bits WIDTH-2..0. This includes equal operands, which give 0, and operands that differ only in bit 0.
- R6: Each edge without reset at which the lower bank loads adds one to `load_cnt_o`. Edges without a load leave it unchanged. Over a run, the count equals the number of presented operand pairs with equal top bits.
- R7: A reset asserted in the middle of a run clears `gt_o`, `lo_load_o` and `load_cnt_o` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | WIDTH | Operand A, unsigned |
| b_i | input | WIDTH | Operand B, unsigned |
| gt_o | output | 1 | A > B for the operands captured at the last edge |
| lo_load_o | output | 1 | Lower bank was loaded at the last edge |
| load_cnt_o | output | CNT_W | Number of lower-bank loads since reset |

## Verification
The hardest case to reach is a skipped cycle that follows a loaded one. The lower bank then still holds stale data from the earlier pair, and only correct selection of the top-bit decision keeps that stale data out of the result. Random operands rarely produce top-bit ties together with lower halves that differ only in bit 0. The stimulus therefore forces the top bits equal in part of the random pairs and sets the lower halves one apart. It also interleaves these pairs with pairs whose top bits differ and whose lower halves are arranged to give the opposite answer.

// File: rtl/pc_cmp_pkg.sv
package pc_cmp_pkg;

    // Registered state of the top-bit stage.
    typedef struct packed {
        logic a_top;
        logic b_top;
    } pc_top_t;

endpackage

// File: rtl/pc_top_stage.sv
module pc_top_stage
    import pc_cmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a_top_i,
    input  logic b_top_i,
    output logic differ_o,
    output logic a_wins_o
);
    pc_top_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.a_top = a_top_i;
        st_d.b_top = b_top_i;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Single-bit decision on the stored top bits.
    assign differ_o = st_q.a_top ^ st_q.b_top;
    assign a_wins_o = st_q.a_top & ~st_q.b_top;
endmodule

// File: rtl/pc_low_bank.sv
module pc_low_bank #(
    parameter int LO_W = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [LO_W-1:0] a_lo_i,
    input  logic [LO_W-1:0] b_lo_i,
    output logic [LO_W-1:0] a_lo_o,
    output logic [LO_W-1:0] b_lo_o
);
    typedef struct packed {
        logic [LO_W-1:0] a_lo;
        logic [LO_W-1:0] b_lo;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (load_i) begin
            bank_d.a_lo = a_lo_i;
            bank_d.b_lo = b_lo_i;
        end
        if (rst) begin
            bank_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    assign a_lo_o = bank_q.a_lo;
    assign b_lo_o = bank_q.b_lo;
endmodule

// File: rtl/pc_low_cmp.sv
module pc_low_cmp #(
    parameter int LO_W = 15
) (
    input  logic [LO_W-1:0] a_i,
    input  logic [LO_W-1:0] b_i,
    output logic            gt_o
);
    // Scan from the top bit down: gt_c/eq_c hold the verdict of bits above i.
    logic [LO_W:0] gt_c;
    logic [LO_W:0] eq_c;

    assign gt_c[LO_W] = 1'b0;
    assign eq_c[LO_W] = 1'b1;

    for (genvar i = LO_W - 1; i >= 0; i--) begin : g_bit
        assign gt_c[i] = gt_c[i+1] | (eq_c[i+1] & a_i[i] & ~b_i[i]);
        assign eq_c[i] = eq_c[i+1] & ~(a_i[i] ^ b_i[i]);
    end

    assign gt_o = gt_c[0];
endmodule

// File: rtl/precomp_gt_cmp.sv
module precomp_gt_cmp #(
    parameter int WIDTH = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             gt_o,
    output logic             lo_load_o,
    output logic [CNT_W-1:0] load_cnt_o
);
    localparam int LO_W = WIDTH - 1;
    localparam int TOP  = WIDTH - 1;

    typedef struct packed {
        logic             loaded;
        logic [CNT_W-1:0] cnt;
    } act_t;

    logic            tops_equal;
    logic            differ;
    logic            a_wins;
    logic            lo_gt;
    logic [LO_W-1:0] a_lo_q;
    logic [LO_W-1:0] b_lo_q;
    act_t            act_d, act_q;

    // Enable for the lower bank, taken from the incoming top bits.
    assign tops_equal = ~(a_i[TOP] ^ b_i[TOP]);

    pc_top_stage u_top (
        .clk      (clk),
        .rst      (rst),
        .a_top_i  (a_i[TOP]),
        .b_top_i  (b_i[TOP]),
        .differ_o (differ),
        .a_wins_o (a_wins)
    );

    pc_low_bank #(.LO_W(LO_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .load_i (tops_equal),
        .a_lo_i (a_i[LO_W-1:0]),
        .b_lo_i (b_i[LO_W-1:0]),
        .a_lo_o (a_lo_q),
        .b_lo_o (b_lo_q)
    );

    pc_low_cmp #(.LO_W(LO_W)) u_cmp (
        .a_i  (a_lo_q),
        .b_i  (b_lo_q),
        .gt_o (lo_gt)
    );

    always_comb begin
        act_d        = act_q;
        act_d.loaded = tops_equal;
        if (tops_equal) begin
            act_d.cnt = act_q.cnt + CNT_W'(1);
        end
        if (rst) begin
            act_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        act_q <= act_d;
    end

    assign gt_o       = differ ? a_wins : lo_gt;
    assign lo_load_o  = act_q.loaded;
    assign load_cnt_o = act_q.cnt;
endmodule

// File: rtl/pc_gt_checker.sv
module pc_gt_checker #(
    parameter int WIDTH = 16,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             gt_o,
    input logic             lo_load_o,
    input logic [CNT_W-1:0] load_cnt_o
);
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!gt_o && !lo_load_o && load_cnt_o == '0));

    a_r2_result: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (gt_o == $past(a_i > b_i)));

    a_r3_top_decides: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(a_i[WIDTH-1] != b_i[WIDTH-1]))
            |-> (gt_o == $past(a_i[WIDTH-1])));

    a_r4_load_flag: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (lo_load_o == $past(a_i[WIDTH-1] == b_i[WIDTH-1])));

    a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (load_cnt_o == $past(load_cnt_o) + CNT_W'(lo_load_o)));
endmodule

bind precomp_gt_cmp pc_gt_checker #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .a_i        (a_i),
    .b_i        (b_i),
    .gt_o       (gt_o),
    .lo_load_o  (lo_load_o),
    .load_cnt_o (load_cnt_o)
);

// File: tb/sim_precomp_gt_cmp.sv
module sim_precomp_gt_cmp;
    localparam int W  = 16;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  a = '0;
    logic [W-1:0]  b = '0;
    logic          gt;
    logic          lo_load;
    logic [CW-1:0] cnt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [CW-1:0] exp_cnt = '0;

    precomp_gt_cmp #(.WIDTH(W), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .a_i(a), .b_i(b),
        .gt_o(gt), .lo_load_o(lo_load), .load_cnt_o(cnt)
    );

    always #2.5 clk = ~clk;

    function automatic logic ref_gt(input logic [W-1:0] x, input logic [W-1:0] y);
        return x > y;
    endfunction

    function automatic logic ref_load(input logic [W-1:0] x, input logic [W-1:0] y);
        return x[W-1] == y[W-1];
    endfunction

    task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present a pair, let one edge pass, check the outputs at the next falling edge.
    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input string req);
        a = x;
        b = y;
        @(negedge clk);
        if (ref_load(x, y)) exp_cnt = exp_cnt + 1;
        check({req, " gt (R2)"}, CW'(gt), CW'(ref_gt(x, y)));
        check("R4 load flag", CW'(lo_load), CW'(ref_load(x, y)));
        check("R6 load count", cnt, exp_cnt);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250));
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 gt", CW'(gt), '0);
        check("R1 load", CW'(lo_load), '0);
        check("R1 count", cnt, '0);
        rst = 1'b0;

        // R5: lower slice decides, load then stale-data skip (R3)
        apply(16'h0002, 16'h0001, "R5");
        apply(16'h8000, 16'h7FFF, "R3");
        apply(16'h7FFF, 16'h8000, "R3");
        apply(16'h1234, 16'h1234, "R5 equal");
        apply(16'hFFFE, 16'hFFFF, "R5 lsb");
        apply(16'hFFFF, 16'hFFFE, "R5 lsb");
        apply(16'h8000, 16'h0FFF, "R3");
        apply(16'h0000, 16'h0000, "R5 zero");
        apply(16'h0001, 16'hFFFF, "R3");

        for (int i = 0; i < 2000; i++) begin
            logic [W-1:0] x, y;
            x = W'($urandom);
            y = W'($urandom);
            case (i % 4)
                1: y = {x[W-1], W'(x[W-2:0] ^ 15'h0001)} & {1'b1, {(W-1){1'b1}}};
                2: y = {~x[W-1], ~x[W-2:0]};
                default: ;
            endcase
            if (i % 4 == 1) y[W-1] = x[W-1];
            apply(x, y, "R2 random");
        end

        // R7: reset in the middle of a run
        a = 16'hF000;
        b = 16'hF000;
        rst = 1'b1;
        @(negedge clk);
        check("R7 gt", CW'(gt), '0);
        check("R7 load", CW'(lo_load), '0);
        check("R7 count", cnt, '0);
        rst = 1'b0;
        exp_cnt = '0;
        apply(16'h4001, 16'h4000, "R7 after");
        apply(16'h4000, 16'hC000, "R3 after");
        check("R6 final count", cnt, CW'(1));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule